// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This filter sits between the bus-side write path and the page write engine of a byte-wide non-volatile memory. Every accepted write (a 13-bit address and an 8-bit data byte) is checked against two fixed unlock codes. A three-write code arms write protection and opens a write window. A six-write code disarms protection. Each write is classed as a command byte, a permitted data byte or a rejected write, and only permitted data bytes reach the downstream port.

While a code is partly matched, its bytes are held in a small queue. If the code completes, the held bytes are dropped. If the code breaks, or times out, the held bytes are either released in order or dropped. Released bytes go out ahead of the write that broke the code, and whether they go out depends on the current protect state.

Both stream edges use valid/ready. An input beat is taken on a cycle where `wr_valid` and `wr_ready` are both high. An output beat is handed over on a cycle where `fw_valid` and `fw_ready` are both high. While any output beat is pending, `wr_ready` is low. Downstream may hold `fw_ready` low for any length of time, and the pending beat stays unchanged until it is taken. `prot_on` and `seq_err` are plain level and pulse outputs.

Top module: `wr_unlock_filter`

## Requirements
- R1: After reset, `prot_on`, `fw_valid` and `seq_err` are 0 and `wr_ready` is 1.
- R2: In the unprotected state, a write that does not start or continue a code appears on `fw_addr`/`fw_data` with `fw_valid` high in the cycle after it is accepted, and `wr_ready` is low while it waits.
- R3: The writes 0xAA at 0x1555, 0x55 at 0x0AAA, then 0xA0 at 0x1555 set `prot_on` in the cycle after the third write, whether or not protection was already on. None of the three is forwarded.
- R4: After the arming code, data writes are forwarded for as long as each one follows the previous accepted write within LOAD_WINDOW cycles. Once LOAD_WINDOW cycles pass with no write, the window closes.
- R5: While protected and outside an open window, a plain write is dropped and `fw_valid` stays low.
- R6: The writes 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 clear `prot_on`, forward nothing and raise no `seq_err`. Afterwards, plain writes are forwarded.
- R7: A write that breaks a partial code pulses `seq_err` high for exactly one cycle and returns the matcher to idle. When unprotected, the held bytes are forwarded in arrival order, followed by the breaking write.
- R8: A code broken while protected, with no open window, forwards neither the held bytes nor the breaking write.
- R9: A partial code that receives no write for LOAD_WINDOW cycles is abandoned: `seq_err` pulses, and when unprotected the held bytes are forwarded in order.
- R10: While `fw_valid` is high and `fw_ready` is low, `fw_valid`, `fw_addr` and `fw_data` hold steady, and no input write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Input write present |
| wr_ready | output | 1 | Filter can take an input write |
| wr_addr | input | 13 | Input write address |
| wr_data | input | 8 | Input write data |
| fw_valid | output | 1 | Forwarded write present |
| fw_ready | input | 1 | Write engine takes the forwarded write |
| fw_addr | output | 13 | Forwarded write address |
| fw_data | output | 8 | Forwarded write data |
| prot_on | output | 1 | Write protection active |
| seq_err | output | 1 | One-cycle pulse when a partial code is abandoned |

## Verification
A wrong match step or a stale queue count shows up at the forward port: bytes are released that should have been dropped, or missing, or out of order. This is visible within one to six output beats of the breaking write. A protect or window flag in the wrong state turns the very next plain write into a wrongly forwarded or wrongly dropped beat, so the directed tests follow every code with a probe write. A timer fault shows up as a missing `seq_err` pulse or a missing release after exactly LOAD_WINDOW idle cycles.

// File: rtl/wuf_pkg.sv
package wuf_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] CMD_ADDR_P = 13'h1555;
  localparam logic [ADDR_W-1:0] CMD_ADDR_Q = 13'h0AAA;
  localparam logic [DATA_W-1:0] KEY_HI     = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_LO     = 8'h55;
  localparam logic [DATA_W-1:0] ARM_BYTE   = 8'hA0;
  localparam logic [DATA_W-1:0] ESC_BYTE   = 8'h80;
  localparam logic [DATA_W-1:0] CLR_BYTE   = 8'h20;

  localparam int SEQ_LONG = 6;
  localparam int STEP_W   = $clog2(SEQ_LONG);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } beat_t;

  typedef enum logic [1:0] {
    V_MISS  = 2'd0,
    V_STEP  = 2'd1,
    V_ARM   = 2'd2,
    V_CLEAR = 2'd3
  } verdict_e;
endpackage

// File: rtl/wuf_seq_match.sv
module wuf_seq_match
  import wuf_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  beat_t             beat,
  output verdict_e          verdict
);
  logic at_p, at_q;

  assign at_p = (beat.addr == CMD_ADDR_P);
  assign at_q = (beat.addr == CMD_ADDR_Q);

  always_comb begin
    verdict = V_MISS;
    case (step)
      STEP_W'(0): if (at_p && beat.data == KEY_HI) verdict = V_STEP;
      STEP_W'(1): if (at_q && beat.data == KEY_LO) verdict = V_STEP;
      STEP_W'(2): begin
        if (at_p && beat.data == ARM_BYTE)      verdict = V_ARM;
        else if (at_p && beat.data == ESC_BYTE) verdict = V_STEP;
      end
      STEP_W'(3): if (at_p && beat.data == KEY_HI)   verdict = V_STEP;
      STEP_W'(4): if (at_q && beat.data == KEY_LO)   verdict = V_STEP;
      STEP_W'(5): if (at_p && beat.data == CLR_BYTE) verdict = V_CLEAR;
      default:    verdict = V_MISS;
    endcase
  end
endmodule

// File: rtl/wuf_hold_queue.sv
module wuf_hold_queue
  import wuf_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  beat_t push_beat,
  input  logic  flush,
  input  logic  release_i,
  input  logic  out_ready,
  output logic  out_valid,
  output beat_t out_beat,
  output logic  busy
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  beat_t         mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] rd;
  logic          draining;
  logic          take;
  logic          room;

  assign room      = (cnt < CW'(DEPTH));
  assign take      = draining && out_ready;
  assign out_valid = draining;
  assign out_beat  = mem[rd[IW-1:0]];
  assign busy      = draining;

  always_ff @(posedge clk) begin
    if (push && room) mem[cnt[IW-1:0]] <= push_beat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt      <= '0;
      rd       <= '0;
      draining <= 1'b0;
    end else begin
      if (push && room) cnt <= cnt + CW'(1);
      if (release_i) draining <= 1'b1;
      if (take) begin
        if (rd == cnt - CW'(1)) begin
          cnt      <= '0;
          rd       <= '0;
          draining <= 1'b0;
        end else begin
          rd <= rd + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wuf_window_timer.sv
module wuf_window_timer #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] tcnt;

  assign expire = !kick && (tcnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || kick)          tcnt <= '0;
    else if (tcnt != TW'(LIMIT)) tcnt <= tcnt + TW'(1);
  end
endmodule

// File: rtl/wr_unlock_filter.sv
module wr_unlock_filter
  import wuf_pkg::*;
#(
  parameter int LOAD_WINDOW = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fw_valid,
  input  logic              fw_ready,
  output logic [ADDR_W-1:0] fw_addr,
  output logic [DATA_W-1:0] fw_data,
  output logic              prot_on,
  output logic              seq_err
);
  localparam int QDEPTH = SEQ_LONG;

  logic [STEP_W-1:0] step_q, step_d;
  logic              prot_q, prot_d;
  logic              grant_q, grant_d;
  logic              err_q, err_d;
  logic              q_push, q_flush, q_release, q_busy;
  logic              accept, expire, permit;
  beat_t             beat_in, beat_out;
  verdict_e          verdict;

  assign beat_in  = '{addr: wr_addr, data: wr_data};
  assign wr_ready = !q_busy;
  assign accept   = wr_valid && wr_ready;
  assign permit   = !prot_q || grant_q;

  wuf_seq_match match_i (
    .step    (step_q),
    .beat    (beat_in),
    .verdict (verdict)
  );

  wuf_window_timer #(.LIMIT(LOAD_WINDOW)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (accept),
    .expire (expire)
  );

  wuf_hold_queue #(.DEPTH(QDEPTH)) queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_beat (beat_in),
    .flush     (q_flush),
    .release_i (q_release),
    .out_ready (fw_ready),
    .out_valid (fw_valid),
    .out_beat  (beat_out),
    .busy      (q_busy)
  );

  always_comb begin
    q_push    = 1'b0;
    q_flush   = 1'b0;
    q_release = 1'b0;
    step_d    = step_q;
    prot_d    = prot_q;
    grant_d   = grant_q;
    err_d     = 1'b0;
    if (accept) begin
      case (verdict)
        V_STEP: begin
          q_push = 1'b1;
          step_d = step_q + STEP_W'(1);
        end
        V_ARM: begin
          q_flush = 1'b1;
          step_d  = '0;
          prot_d  = 1'b1;
          grant_d = 1'b1;
        end
        V_CLEAR: begin
          q_flush = 1'b1;
          step_d  = '0;
          prot_d  = 1'b0;
          grant_d = 1'b0;
        end
        default: begin
          step_d = '0;
          err_d  = (step_q != '0);
          if (permit) begin
            q_push    = 1'b1;
            q_release = 1'b1;
          end else begin
            q_flush = 1'b1;
          end
        end
      endcase
    end else if (expire) begin
      grant_d = 1'b0;
      if (step_q != '0) begin
        step_d = '0;
        err_d  = 1'b1;
        if (permit) q_release = 1'b1;
        else        q_flush   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= '0;
      prot_q  <= 1'b0;
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      step_q  <= step_d;
      prot_q  <= prot_d;
      grant_q <= grant_d;
      err_q   <= err_d;
    end
  end

  assign fw_addr = beat_out.addr;
  assign fw_data = beat_out.data;
  assign prot_on = prot_q;
  assign seq_err = err_q;
endmodule

// File: rtl/wuf_checker.sv
module wuf_checker
  import wuf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              fw_valid,
  input logic              fw_ready,
  input logic [ADDR_W-1:0] fw_addr,
  input logic [DATA_W-1:0] fw_data,
  input logic              prot_on,
  input logic              seq_err
);
  // R10
  fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid && !fw_ready |=> fw_valid && $stable(fw_addr) && $stable(fw_data));

  // R3
  arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(wr_valid && wr_ready && wr_addr == CMD_ADDR_P && wr_data == ARM_BYTE));

  // R6
  clear_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(wr_valid && wr_ready && wr_addr == CMD_ADDR_P && wr_data == CLR_BYTE));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);

  // R10
  no_take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid && !fw_ready |=> !$past(wr_valid && wr_ready));
endmodule

bind wr_unlock_filter wuf_checker chk_i (.*);

// File: tb/wr_unlock_filter_tb.sv
module wr_unlock_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        fw_valid;
  logic        fw_ready = 1'b1;
  logic [12:0] fw_addr;
  logic [7:0]  fw_data;
  logic        prot_on;
  logic        seq_err;

  int n_chk = 0;
  int n_err = 0;
  int err_seen = 0;
  logic [20:0] got [32];
  logic [20:0] want [32];
  int got_n = 0;
  int want_n = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wr_unlock_filter #(.LOAD_WINDOW(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_addr(fw_addr), .fw_data(fw_data),
    .prot_on(prot_on), .seq_err(seq_err)
  );

  always @(negedge clk) begin
    if (rst_n && fw_valid && fw_ready && got_n < 32) begin
      got[got_n] = {fw_addr, fw_data};
      got_n = got_n + 1;
    end
    if (rst_n && seq_err) err_seen = err_seen + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(input logic [12:0] a, input logic [7:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic expect_beat(input logic [12:0] a, input logic [7:0] d);
    want[want_n] = {a, d};
    want_n = want_n + 1;
  endtask

  task automatic compare_log(input string req);
    check(got_n == want_n, {req, " beat count"}, got_n, want_n);
    for (int i = 0; i < want_n && i < got_n; i++)
      check(got[i] == want[i], {req, " beat order"}, int'(got[i]), int'(want[i]));
    got_n = 0;
    want_n = 0;
  endtask

  task automatic arm();
    send(13'h1555, 8'hAA);
    send(13'h0AAA, 8'h55);
    send(13'h1555, 8'hA0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(prot_on == 1'b0, "R1 prot_on", prot_on, 0);
    check(fw_valid == 1'b0, "R1 fw_valid", fw_valid, 0);
    check(seq_err == 1'b0, "R1 seq_err", seq_err, 0);
    check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    tick();
  endtask

  task automatic t_plain();
    send(13'h0123, 8'h3C);
    @(negedge clk);
    check(fw_valid == 1'b1, "R2 fw_valid next cycle", fw_valid, 1);
    check({fw_addr, fw_data} == {13'h0123, 8'h3C}, "R2 beat", int'({fw_addr, fw_data}), int'({13'h0123, 8'h3C}));
    check(wr_ready == 1'b0, "R2 wr_ready low while pending", wr_ready, 0);
    tick();
    send(13'h1FFF, 8'h00);
    send(13'h1555, 8'h55);
    idle(3);
    expect_beat(13'h0123, 8'h3C);
    expect_beat(13'h1FFF, 8'h00);
    expect_beat(13'h1555, 8'h55);
    compare_log("R2");
  endtask

  task automatic t_backpressure();
    fw_ready = 1'b0;
    send(13'h0042, 8'h99);
    wr_valid = 1'b1;
    wr_addr  = 13'h0043;
    wr_data  = 8'h77;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(fw_valid && {fw_addr, fw_data} == {13'h0042, 8'h99}, "R10 held beat",
            int'({fw_addr, fw_data}), int'({13'h0042, 8'h99}));
      check(wr_ready == 1'b0, "R10 no accept", wr_ready, 0);
      tick();
    end
    wr_valid = 1'b0;
    fw_ready = 1'b1;
    idle(3);
    expect_beat(13'h0042, 8'h99);
    compare_log("R10");
  endtask

  task automatic t_break_open();
    int e0;
    e0 = err_seen;
    send(13'h1555, 8'hAA);
    send(13'h0AAA, 8'h55);
    send(13'h0100, 8'h33);
    idle(6);
    expect_beat(13'h1555, 8'hAA);
    expect_beat(13'h0AAA, 8'h55);
    expect_beat(13'h0100, 8'h33);
    compare_log("R7 short");
    check(err_seen == e0 + 1, "R7 one err pulse", err_seen - e0, 1);
    send(13'h1555, 8'hAA);
    send(13'h0AAA, 8'h55);
    send(13'h1555, 8'h80);
    send(13'h1555, 8'hAA);
    send(13'h0005, 8'h12);
    idle(10);
    expect_beat(13'h1555, 8'hAA);
    expect_beat(13'h0AAA, 8'h55);
    expect_beat(13'h1555, 8'h80);
    expect_beat(13'h1555, 8'hAA);
    expect_beat(13'h0005, 8'h12);
    compare_log("R7 long");
    check(err_seen == e0 + 2, "R7 second err pulse", err_seen - e0, 2);
  endtask

  task automatic t_timeout();
    int e0;
    e0 = err_seen;
    send(13'h1555, 8'hAA);
    idle(WIN - 5);
    check(got_n == 0 && err_seen == e0, "R9 held before expiry", got_n, 0);
    idle(15);
    expect_beat(13'h1555, 8'hAA);
    compare_log("R9");
    check(err_seen == e0 + 1, "R9 err pulse", err_seen - e0, 1);
  endtask

  task automatic t_arm_window();
    arm();
    @(negedge clk);
    check(prot_on == 1'b1, "R3 prot set", prot_on, 1);
    tick();
    send(13'h0200, 8'h01);
    send(13'h0201, 8'h02);
    idle(3);
    expect_beat(13'h0200, 8'h01);
    expect_beat(13'h0201, 8'h02);
    compare_log("R4 window");
    idle(WIN + 10);
    send(13'h0202, 8'h03);
    idle(4);
    compare_log("R5 dropped");
    check(prot_on == 1'b1, "R5 still protected", prot_on, 1);
    arm();
    send(13'h0203, 8'h04);
    idle(3);
    expect_beat(13'h0203, 8'h04);
    compare_log("R3 rearm");
    check(prot_on == 1'b1, "R3 prot after rearm", prot_on, 1);
    idle(WIN + 10);
  endtask

  task automatic t_break_locked();
    int e0;
    e0 = err_seen;
    send(13'h1555, 8'hAA);
    send(13'h0200, 8'h11);
    idle(8);
    compare_log("R8");
    check(err_seen == e0 + 1, "R8 err pulse", err_seen - e0, 1);
    check(prot_on == 1'b1, "R8 still protected", prot_on, 1);
  endtask

  task automatic t_cancel();
    int e0;
    e0 = err_seen;
    send(13'h1555, 8'hAA);
    send(13'h0AAA, 8'h55);
    send(13'h1555, 8'h80);
    send(13'h1555, 8'hAA);
    send(13'h0AAA, 8'h55);
    send(13'h1555, 8'h20);
    @(negedge clk);
    check(prot_on == 1'b0, "R6 prot cleared", prot_on, 0);
    tick();
    idle(4);
    compare_log("R6 nothing forwarded");
    check(err_seen == e0, "R6 no err", err_seen - e0, 0);
    send(13'h0300, 8'h5A);
    idle(3);
    expect_beat(13'h0300, 8'h5A);
    compare_log("R6 plain after");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err = n_err + 1;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_backpressure();
    t_break_open();
    t_timeout();
    t_arm_window();
    t_break_locked();
    t_cancel();
    finish_run();
  end
endmodule